// File: doc/BRIEF.md
# Complementary PWM Generator with Selectable Duty Banks and Dead-Time

This block drives three inverter legs. Each leg gets a complementary pair of outputs: a top output and a bottom output. An internal edge-aligned period counter runs from 0 to MODULUS-1 and repeats. A period-start flag is exported on `cycleStart`. Each pair owns two duty registers. Software fills both registers ahead of time, one for each direction of phase current. A per-pair polarity bit then picks which of the two sets the duty. The polarity bit is sampled only at the period boundary, so one period never mixes the two registers.

Duty writes first land in a buffer. The buffer is copied into the active duty only at a period boundary, and only while `loadOk` is high. The polarity bits do not depend on `loadOk`: they are latched at every boundary. Manual selection is in force only while `senseAuto` is low. `senseAuto` stands for the upper bit of a current-sense mode field.

The compare result of each pair passes through a dead-time stage. This stage holds both outputs low for `deadTime` clock cycles after every change of the compare result.

Top module: `comp_pwm_dtc`

## Requirements
- R1: While `rst` is high, and on the cycle after the first clock edge with `rst` high, `pwmTop`, `pwmBot` and `cycleStart` are all 0.
- R2: The period counter counts 0 to MODULUS-1 and wraps. `cycleStart` is high exactly in the cycles where the count is 0, so it pulses once every MODULUS cycles and is never high two cycles in a row.
- R3: Pair p has two duty registers. The first is at write address 2p and the second at address 2p+1. Latched polarity 0 selects the first register and latched polarity 1 selects the second.
- R4: A change of `polSel[p]` within a period has no effect until the period boundary, which is the edge where the count wraps to 0.
- R5: At every boundary the polarity bits are latched whatever the level of `loadOk`.
- R6: A write stores `wrData` in the buffer of register `wrAddr`. Buffers are copied to the active duties at a boundary only when `loadOk` is high at that edge. Otherwise the active duties keep their values.
- R7: Before dead-time, a pair's raw top signal is high in every cycle where count < selected active duty.
- R8: After each change of a raw top signal, both outputs of that pair stay low for `deadTime` cycles. After that, top follows the raw signal and bottom is its complement. Top and bottom of a pair are never high together.
- R9: An active duty of 0 keeps the top output low and the bottom output high for the whole period. An active duty of MODULUS or more keeps the top output high for the whole period. Neither case produces a dead-time gap at the period boundary.
- R10: While `senseAuto` is 1, the latched polarity bits hold their value at boundaries and `polSel` is ignored.
- R11: Writes to addresses 6 and 7 change no duty register.
- R12: Reset clears all buffers, all active duties and all latched polarity bits to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Duty buffer write strobe |
| wrAddr | input | 3 | Duty register index (0..5) |
| wrData | input | 8 | Duty value to write |
| loadOk | input | 1 | Allows buffer-to-active copy at the boundary |
| polSel | input | 3 | Per-pair polarity (register select) bits |
| senseAuto | input | 1 | Upper bit of the current-sense mode; 1 freezes manual selection |
| deadTime | input | 3 | Dead-time length in clock cycles |
| cycleStart | output | 1 | High while the period count is 0 |
| pwmTop | output | 3 | Top output per pair |
| pwmBot | output | 3 | Bottom output per pair |

## Verification
The bench changes the polarity bits in the middle of a period, with `loadOk` both high and low. A design that latched the bits at once, or only under `loadOk`, would switch duty banks inside a period or miss a switch. Duties of 0, exactly MODULUS and above MODULUS are run across several boundaries to catch a stray dead-time notch or a one-cycle pulse at the wrap. Dead times of 0, 2 and 5 are combined with pulses narrower than the dead time. This exposes a gap that is one cycle too short or too long, and any overlap of top and bottom. Writes held back by a low `loadOk`, writes to the unused addresses, and frozen selection under `senseAuto` show up as wrong duty widths if they leak through.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  // strobes from the timebase control to the duty datapath
  typedef struct packed {
    logic boundary;    // count wraps at this edge
    logic loadActive;  // copy buffers into active duties
    logic latchSel;    // capture the polarity bits
  } ctrlStrobes_t;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import cpwm_pkg::*;
#(
  parameter int MODULUS = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          loadOk,
  input  logic          senseAuto,
  output ctrlStrobes_t  strobes,
  output logic [CW-1:0] count,
  output logic          cycleStart
);
  localparam logic [CW-1:0] LAST = CW'(MODULUS - 1);

  logic [CW-1:0] cnt;
  logic armed;
  logic atLast;

  assign atLast = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
      cnt   <= atLast ? '0 : cnt + CW'(1);
    end
  end

  always_comb begin
    strobes.boundary   = atLast;
    strobes.loadActive = atLast & loadOk;
    strobes.latchSel   = atLast & ~senseAuto;
  end

  assign count      = cnt;
  assign cycleStart = armed & (cnt == '0);
endmodule

// File: rtl/pwm_dutypath.sv
module pwm_dutypath
  import cpwm_pkg::*;
#(
  parameter int NPAIR = 3,
  parameter int DW = 8,
  parameter int CW = 4,
  parameter int AW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobes_t     strobes,
  input  logic [CW-1:0]    count,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [DW-1:0]    wrData,
  input  logic [NPAIR-1:0] polSel,
  output logic [NPAIR-1:0] rawTop,
  output logic [NPAIR-1:0] selQ
);
  localparam int NREG = 2 * NPAIR;

  logic [DW-1:0] dutyBuf [NREG];
  logic [DW-1:0] dutyAct [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin
        dutyBuf[i] <= '0;
        dutyAct[i] <= '0;
      end
      selQ <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wrEn && wrAddr == AW'(i)) dutyBuf[i] <= wrData;
        if (strobes.loadActive) dutyAct[i] <= dutyBuf[i];
      end
      if (strobes.latchSel) selQ <= polSel;
    end
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_cmp
    logic [DW-1:0] dutySel;
    assign dutySel   = selQ[p] ? dutyAct[2*p+1] : dutyAct[2*p];
    assign rawTop[p] = (DW'(count) < dutySel);
  end
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int DTW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rawIn,
  input  logic [DTW-1:0] deadTime,
  output logic           top,
  output logic           bot
);
  logic rawQ;
  logic armed;
  logic [DTW-1:0] dtCnt;
  logic settled;

  always_ff @(posedge clk) begin
    if (rst) begin
      rawQ  <= 1'b0;
      armed <= 1'b0;
      dtCnt <= '0;
    end else begin
      armed <= 1'b1;
      if (rawIn != rawQ) begin
        rawQ  <= rawIn;
        dtCnt <= deadTime;
      end else if (dtCnt != '0) begin
        dtCnt <= dtCnt - DTW'(1);
      end
    end
  end

  assign settled = armed & (dtCnt == '0);
  assign top = settled & rawQ;
  assign bot = settled & ~rawQ;
endmodule

// File: rtl/comp_pwm_dtc.sv
module comp_pwm_dtc
  import cpwm_pkg::*;
#(
  parameter int NPAIR = 3,
  parameter int DW = 8,
  parameter int MODULUS = 16,
  parameter int DTW = 3,
  localparam int NREG = 2 * NPAIR,
  localparam int AW = $clog2(NREG),
  localparam int CW = (MODULUS > 1) ? $clog2(MODULUS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [DW-1:0]    wrData,
  input  logic             loadOk,
  input  logic [NPAIR-1:0] polSel,
  input  logic             senseAuto,
  input  logic [DTW-1:0]   deadTime,
  output logic             cycleStart,
  output logic [NPAIR-1:0] pwmTop,
  output logic [NPAIR-1:0] pwmBot
);
  ctrlStrobes_t strobes;
  logic [CW-1:0] count;
  logic [NPAIR-1:0] rawTop;
  logic [NPAIR-1:0] selQ;

  pwm_timebase #(.MODULUS(MODULUS), .CW(CW)) u_tb (
    .clk(clk), .rst(rst), .loadOk(loadOk), .senseAuto(senseAuto),
    .strobes(strobes), .count(count), .cycleStart(cycleStart)
  );

  pwm_dutypath #(.NPAIR(NPAIR), .DW(DW), .CW(CW), .AW(AW)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .count(count),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .polSel(polSel),
    .rawTop(rawTop), .selQ(selQ)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_leg
    pwm_deadband #(.DTW(DTW)) u_db (
      .clk(clk), .rst(rst), .rawIn(rawTop[p]), .deadTime(deadTime),
      .top(pwmTop[p]), .bot(pwmBot[p])
    );
  end
endmodule

// File: rtl/comp_pwm_dtc_chk.sv
module comp_pwm_dtc_chk #(
  parameter int NPAIR = 3,
  parameter int DTW = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             cycleStart,
  input logic [NPAIR-1:0] pwmTop,
  input logic [NPAIR-1:0] pwmBot,
  input logic [NPAIR-1:0] selQ,
  input logic [DTW-1:0]   deadTime
);
  // R8
  never_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    (pwmTop & pwmBot) == '0);

  // R8
  dead_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (deadTime != '0) |-> ((pwmTop & ~$past(pwmTop) & $past(pwmBot)) == '0));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (pwmTop == '0 && pwmBot == '0 && !cycleStart));

  // R4
  sel_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(selQ) |-> cycleStart);

  // R2
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    cycleStart |=> !cycleStart);
endmodule

bind comp_pwm_dtc comp_pwm_dtc_chk #(.NPAIR(NPAIR), .DTW(DTW)) u_chk (
  .clk(clk), .rst(rst), .cycleStart(cycleStart), .pwmTop(pwmTop),
  .pwmBot(pwmBot), .selQ(selQ), .deadTime(deadTime)
);

// File: tb/sim_comp_pwm_dtc.sv
module sim_comp_pwm_dtc;
  localparam int MOD = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic loadOk = 1'b0;
  logic [2:0] polSel = '0;
  logic senseAuto = 1'b0;
  logic [2:0] deadTime = 3'd2;
  logic cycleStart;
  logic [2:0] pwmTop, pwmBot;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string phase = "R1";

  comp_pwm_dtc u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .loadOk(loadOk), .polSel(polSel), .senseAuto(senseAuto),
    .deadTime(deadTime), .cycleStart(cycleStart), .pwmTop(pwmTop),
    .pwmBot(pwmBot)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [2:0] top;
    logic [2:0] bot;
    logic cs;
  } exp_t;
  exp_t expQ[$];

  // requirement-level model: counter, banks, polarity, sliding raw window
  int mCnt;
  bit mArmed;
  logic [2:0] mSel;
  logic [7:0] mBuf[6];
  logic [7:0] mAct[6];
  logic [15:0] hist[3];

  always @(posedge clk) begin
    exp_t e;
    logic [15:0] mask;
    bit bnd;
    if (rst) begin
      mCnt = 0; mArmed = 0; mSel = '0;
      for (int i = 0; i < 6; i++) begin mBuf[i] = '0; mAct[i] = '0; end
      for (int p = 0; p < 3; p++) hist[p] = '0;
    end else begin
      for (int p = 0; p < 3; p++) begin
        int d;
        d = mAct[2*p + int'(mSel[p])];
        hist[p] = {hist[p][14:0], (mCnt < d)};
      end
      bnd = (mCnt == MOD - 1);
      if (bnd && loadOk) for (int i = 0; i < 6; i++) mAct[i] = mBuf[i];
      if (wrEn && wrAddr < 3'd6) mBuf[wrAddr] = wrData;
      if (bnd && !senseAuto) mSel = polSel;
      mCnt = bnd ? 0 : mCnt + 1;
      mArmed = 1;
    end
    mask = (16'h1 << (int'(deadTime) + 1)) - 16'h1;
    for (int p = 0; p < 3; p++) begin
      e.top[p] = mArmed && ((hist[p] & mask) == mask);
      e.bot[p] = mArmed && ((hist[p] & mask) == 16'h0);
    end
    e.cs = mArmed && (mCnt == 0);
    expQ.push_back(e);
  end

  // monitor: compare the design against the scoreboard away from the edge
  always @(negedge clk) begin
    if (!done && expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      checks++;
      if (pwmTop !== e.top || pwmBot !== e.bot || cycleStart !== e.cs) begin
        fails++;
        $display("FAIL %s: top=%b bot=%b cs=%b expected top=%b bot=%b cs=%b",
                 phase, pwmTop, pwmBot, cycleStart, e.top, e.bot, e.cs);
      end
      checks++;
      if ((pwmTop & pwmBot) != 3'b000) begin
        fails++;
        $display("FAIL R8 overlap: top=%b bot=%b expected no common bit", pwmTop, pwmBot);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeDuty(input int a, input int v);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'(a); wrData = 8'(v);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doReset(input int dt);
    @(negedge clk);
    rst = 1'b1; deadTime = 3'(dt);
    cyc(3);
    rst = 1'b0;
  endtask

  initial begin
    // R1 / R12 reset state
    phase = "R1";
    cyc(2);
    checks++;
    if (pwmTop !== 3'b0 || pwmBot !== 3'b0 || cycleStart !== 1'b0) begin
      fails++;
      $display("FAIL R1: top=%b bot=%b cs=%b expected 000 000 0", pwmTop, pwmBot, cycleStart);
    end
    rst = 1'b0;
    phase = "R12"; cyc(MOD + 4);
    // R7 basic compare with bank 0 registers, R2 period
    phase = "R7";
    loadOk = 1'b1;
    writeDuty(0, 5); writeDuty(1, 10); writeDuty(2, 3);
    writeDuty(3, 12); writeDuty(4, 8); writeDuty(5, 1);
    cyc(3 * MOD);
    phase = "R2"; cyc(2 * MOD);
    // R3/R4 mid-period polarity change
    phase = "R3";
    cyc(5); polSel = 3'b101;
    phase = "R4"; cyc(3 * MOD);
    // R5 polarity latched without load-okay
    phase = "R5";
    loadOk = 1'b0; cyc(7); polSel = 3'b010; cyc(3 * MOD);
    // R6 writes held back, then released
    phase = "R6";
    writeDuty(0, 14); writeDuty(3, 2); writeDuty(5, 9);
    cyc(2 * MOD);
    loadOk = 1'b1; cyc(2 * MOD);
    // R11 unused addresses
    phase = "R11";
    writeDuty(6, 200); writeDuty(7, 77); cyc(2 * MOD);
    // R9 extremes: 0, exactly modulus, above modulus
    phase = "R9";
    polSel = 3'b000;
    writeDuty(0, 0); writeDuty(2, MOD); writeDuty(4, 255);
    cyc(4 * MOD);
    // R10 frozen selection
    phase = "R10";
    writeDuty(0, 4); writeDuty(1, 11);
    cyc(MOD);
    senseAuto = 1'b1; polSel = 3'b111; cyc(3 * MOD);
    senseAuto = 1'b0; cyc(2 * MOD);
    // R8 zero dead-time, then long dead-time with narrow pulses
    phase = "R8";
    doReset(0);
    loadOk = 1'b1;
    writeDuty(0, 6); writeDuty(2, 15); writeDuty(4, 1);
    cyc(3 * MOD);
    doReset(5);
    writeDuty(0, 2); writeDuty(2, 14); writeDuty(4, 9); writeDuty(5, 3);
    cyc(2 * MOD); polSel = 3'b100; cyc(3 * MOD);
    phase = "R12";
    doReset(2); cyc(2 * MOD);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule